// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block follows the CPU through its three power states (running, halted and sleeping) and decides which incoming events bring the CPU back to running. A halt or sleep command from the CPU moves the block into the matching low-power state. The block then watches only the wake sources that belong to that state. When one of them is present, the block raises the CPU run enable on the next clock edge.

When the CPU wakes, the block also tells it how to resume. It either branches to an interrupt handler or continues with the instruction after the halt or sleep. A branch happens only when the interrupt controller is requesting service and the CPU is currently able to accept interrupts. Wake-up does not depend on interrupt priority levels. Port and real-time-clock lines, however, wake the CPU only when their own enable bits are set. Either reset source returns the CPU to running with a plain resume, subject to the sleep restriction in R5.

Top module: `lpwr_wake_ctrl`

## Requirements
- R1: In HALT, each of the following moves the block to RUN, with `cpuRunEn` rising on the edge that samples it: `itcReq`, `wdtNmi`, `nmiPinN` low, `dbgInt`, `wdtRst`, `extRst`.
- R2: In SLEEP, only these move the block to RUN: an enabled port line, an enabled RTC line, `nmiPinN` low, or `extRst`. The inputs `wdtNmi`, `wdtRst`, `dbgInt` and `itcReq` leave it asleep.
- R3: Port line i (or RTC line i) counts as a wake source only while its enable bit i is 1. These lines never wake from HALT. No priority-level input exists.
- R4: On a wake, `enterHandler` is loaded with 1 only if `itcReq` and `cpuIntAccept` are both 1 in the wake cycle. Otherwise it is loaded with 0.
- R5: `extRst` forces RUN with `enterHandler` 0 on the next edge from any state. `wdtRst` does the same from RUN or HALT.
- R6: The NMI pin `nmiPinN` is active low. A 0 is an NMI event.
- R7: In RUN, a halt command is ignored while any HALT wake source is asserted. A sleep command is ignored while any SLEEP wake source is asserted.
- R8: If `haltCmd` and `sleepCmd` are both 1 in RUN, the block enters HALT.
- R9: Commands act only in RUN. In HALT or SLEEP, `cpuRunEn` stays 0 until a wake. In RUN, `cpuRunEn` stays 1 and `enterHandler` holds its value until a command is accepted. Entering a low-power state clears `enterHandler`.
- R10: While `rstN` is low, the block is in RUN with `cpuRunEn` 1 and `enterHandler` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| haltCmd | input | 1 | CPU request to enter HALT |
| sleepCmd | input | 1 | CPU request to enter SLEEP |
| itcReq | input | 1 | Interrupt controller request to the CPU |
| cpuIntAccept | input | 1 | CPU can currently accept a maskable interrupt |
| wdtNmi | input | 1 | Watchdog NMI |
| nmiPinN | input | 1 | External NMI pin, active low |
| dbgInt | input | 1 | Debug interrupt |
| wdtRst | input | 1 | Watchdog reset request |
| extRst | input | 1 | External reset pin request, active high |
| portIrq | input | PORT_LINES | Port input interrupt lines |
| portIrqEn | input | PORT_LINES | Per-line port interrupt enables |
| rtcIrq | input | RTC_LINES | Real-time-clock interrupt lines |
| rtcIrqEn | input | RTC_LINES | Per-line RTC interrupt enables |
| cpuRunEn | output | 1 | CPU may run |
| enterHandler | output | 1 | 1: branch to the handler after wake; 0: continue after the halt or sleep instruction |

## Verification
On every cycle, the assertions check the following:
- A HALT wake source always ends HALT one edge later.
- SLEEP persists while no sleep source is present.
- A blocked command leaves the block in RUN.
- The run enable always agrees with the control state.
- A reset pin request always yields a plain resume.
- A rise of the handler flag always has an accepted interrupt request behind it.

Only the bench's scenarios can show which of the eleven wake inputs each power state responds to. They also show that a port or RTC line is masked by its enable, and that halt wins over sleep when both commands arrive together. Further scenarios show that the resume flag survives idle run cycles and that commands given while asleep have no effect.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
package wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_SLEEP = 2'd2
  } pwrState_t;

  // strobes from control to output datapath
  typedef struct packed {
    logic goLow;     // a low-power state is being entered
    logic wake;      // ordinary wake, resume flag is loaded
    logic forceRun;  // reset-driven return to RUN, resume flag cleared
  } dpStrobe_t;

  // qualified wake conditions handed to the control
  typedef struct packed {
    logic haltWake;
    logic sleepWake;
    logic extReset;
    logic wdtReset;
  } wakeQual_t;

endpackage

// File: rtl/wake_qual.sv
`timescale 1ns/1ps
module wake_qual
  import wake_pkg::*;
#(
  parameter int PORT_LINES = 4,
  parameter int RTC_LINES  = 1
) (
  input  logic                  itcReq,
  input  logic                  cpuIntAccept,
  input  logic                  wdtNmi,
  input  logic                  nmiPinN,
  input  logic                  dbgInt,
  input  logic                  wdtRst,
  input  logic                  extRst,
  input  logic [PORT_LINES-1:0] portIrq,
  input  logic [PORT_LINES-1:0] portIrqEn,
  input  logic [RTC_LINES-1:0]  rtcIrq,
  input  logic [RTC_LINES-1:0]  rtcIrqEn,
  output wakeQual_t             qual,
  output logic                  handlerOk
);

  logic [PORT_LINES-1:0] portHitVec;
  logic [RTC_LINES-1:0]  rtcHitVec;
  logic                  nmiEvent;
  logic                  portHit;
  logic                  rtcHit;

  // each line is gated by its own enable bit
  for (genvar i = 0; i < PORT_LINES; i++) begin : g_port
    assign portHitVec[i] = portIrq[i] & portIrqEn[i];
  end
  for (genvar j = 0; j < RTC_LINES; j++) begin : g_rtc
    assign rtcHitVec[j] = rtcIrq[j] & rtcIrqEn[j];
  end

  assign portHit  = |portHitVec;
  assign rtcHit   = |rtcHitVec;
  assign nmiEvent = ~nmiPinN;

  always_comb begin
    qual.haltWake  = itcReq | wdtNmi | nmiEvent | dbgInt | wdtRst | extRst;
    qual.sleepWake = portHit | rtcHit | nmiEvent | extRst;
    qual.extReset  = extRst;
    qual.wdtReset  = wdtRst;
  end

  assign handlerOk = itcReq & cpuIntAccept;

  // a masked port line alone can never form a sleep wake
  always_comb begin
    if ((portIrqEn == '0) && !rtcHit && nmiPinN && !extRst)
      assert (!qual.sleepWake) else $error("AST_MASKED_PORT_QUIET"); // R3
  end

endmodule

// File: rtl/wake_fsm.sv
`timescale 1ns/1ps
module wake_fsm
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltCmd,
  input  logic       sleepCmd,
  input  wakeQual_t  qual,
  output dpStrobe_t  strobe,
  output pwrState_t  state
);

  pwrState_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_RUN: begin
        if (qual.extReset || qual.wdtReset) begin
          strobe.forceRun = 1'b1;
        end else if (haltCmd && !qual.haltWake) begin
          nextState    = ST_HALT;
          strobe.goLow = 1'b1;
        end else if (sleepCmd && !haltCmd && !qual.sleepWake) begin
          nextState    = ST_SLEEP;
          strobe.goLow = 1'b1;
        end
      end
      ST_HALT: begin
        if (qual.haltWake) begin
          nextState = ST_RUN;
          if (qual.extReset || qual.wdtReset) strobe.forceRun = 1'b1;
          else                                strobe.wake     = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (qual.sleepWake) begin
          nextState = ST_RUN;
          if (qual.extReset) strobe.forceRun = 1'b1;
          else               strobe.wake     = 1'b1;
        end
      end
      default: begin
        nextState       = ST_RUN;
        strobe.forceRun = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  AST_HALT_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && qual.haltWake) |=> (state == ST_RUN)) else $error("AST_HALT_WAKES"); // R1

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !qual.sleepWake) |=> (state == ST_SLEEP)) else $error("AST_SLEEP_HOLDS"); // R2

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && !qual.haltWake) |=> (state == ST_HALT)) else $error("AST_HALT_HOLDS"); // R9

  AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && haltCmd && qual.haltWake) |=> (state == ST_RUN)) else $error("AST_CMD_BLOCKED"); // R7

  AST_HALT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && haltCmd && sleepCmd) |=> (state != ST_SLEEP)) else $error("AST_HALT_FIRST"); // R8

endmodule

// File: rtl/wake_out.sv
`timescale 1ns/1ps
module wake_out
  import wake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  logic      handlerOk,
  output logic      cpuRunEn,
  output logic      enterHandler
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRunEn     <= 1'b1;
      enterHandler <= 1'b0;
    end else if (strobe.forceRun) begin
      cpuRunEn     <= 1'b1;
      enterHandler <= 1'b0;
    end else if (strobe.wake) begin
      cpuRunEn     <= 1'b1;
      enterHandler <= handlerOk;
    end else if (strobe.goLow) begin
      cpuRunEn     <= 1'b0;
      enterHandler <= 1'b0;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.forceRun, strobe.wake, strobe.goLow})) else $error("AST_ONE_STROBE"); // R9

endmodule

// File: rtl/lpwr_wake_ctrl.sv
`timescale 1ns/1ps
module lpwr_wake_ctrl
  import wake_pkg::*;
#(
  parameter int PORT_LINES = 4,
  parameter int RTC_LINES  = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  haltCmd,
  input  logic                  sleepCmd,
  input  logic                  itcReq,
  input  logic                  cpuIntAccept,
  input  logic                  wdtNmi,
  input  logic                  nmiPinN,
  input  logic                  dbgInt,
  input  logic                  wdtRst,
  input  logic                  extRst,
  input  logic [PORT_LINES-1:0] portIrq,
  input  logic [PORT_LINES-1:0] portIrqEn,
  input  logic [RTC_LINES-1:0]  rtcIrq,
  input  logic [RTC_LINES-1:0]  rtcIrqEn,
  output logic                  cpuRunEn,
  output logic                  enterHandler
);

  wakeQual_t  qual;
  dpStrobe_t  strobe;
  pwrState_t  state;
  logic       handlerOk;

  wake_qual #(.PORT_LINES(PORT_LINES), .RTC_LINES(RTC_LINES)) u_qual (
    .itcReq(itcReq), .cpuIntAccept(cpuIntAccept), .wdtNmi(wdtNmi),
    .nmiPinN(nmiPinN), .dbgInt(dbgInt), .wdtRst(wdtRst), .extRst(extRst),
    .portIrq(portIrq), .portIrqEn(portIrqEn), .rtcIrq(rtcIrq),
    .rtcIrqEn(rtcIrqEn), .qual(qual), .handlerOk(handlerOk)
  );

  wake_fsm u_fsm (
    .clk(clk), .rstN(rstN), .haltCmd(haltCmd), .sleepCmd(sleepCmd),
    .qual(qual), .strobe(strobe), .state(state)
  );

  wake_out u_out (
    .clk(clk), .rstN(rstN), .strobe(strobe), .handlerOk(handlerOk),
    .cpuRunEn(cpuRunEn), .enterHandler(enterHandler)
  );

  AST_RUN_TRACKS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    cpuRunEn == (state == ST_RUN)) else $error("AST_RUN_TRACKS_STATE"); // R9

  AST_PIN_RESET_PLAIN: assert property (@(posedge clk) disable iff (!rstN)
    extRst |=> (cpuRunEn && !enterHandler)) else $error("AST_PIN_RESET_PLAIN"); // R5

  AST_HANDLER_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enterHandler) |-> $past(itcReq && cpuIntAccept)) else $error("AST_HANDLER_CAUSE"); // R4

  AST_NO_HANDLER_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRunEn |-> !enterHandler) else $error("AST_NO_HANDLER_ASLEEP"); // R9

endmodule

// File: tb/sim_lpwr_wake_ctrl.sv
`timescale 1ns/1ps
module sim_lpwr_wake_ctrl;

  localparam int PL = 4;
  localparam int RL = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltCmd = 0, sleepCmd = 0, itcReq = 0, cpuIntAccept = 0;
  logic wdtNmi = 0, nmiPinN = 1, dbgInt = 0, wdtRst = 0, extRst = 0;
  logic [PL-1:0] portIrq = '0, portIrqEn = '0;
  logic [RL-1:0] rtcIrq = '0, rtcIrqEn = '0;
  logic cpuRunEn, enterHandler;

  int runCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  lpwr_wake_ctrl #(.PORT_LINES(PL), .RTC_LINES(RL)) u0 (
    .clk(clk), .rstN(rstN), .haltCmd(haltCmd), .sleepCmd(sleepCmd),
    .itcReq(itcReq), .cpuIntAccept(cpuIntAccept), .wdtNmi(wdtNmi),
    .nmiPinN(nmiPinN), .dbgInt(dbgInt), .wdtRst(wdtRst), .extRst(extRst),
    .portIrq(portIrq), .portIrqEn(portIrqEn), .rtcIrq(rtcIrq),
    .rtcIrqEn(rtcIrqEn), .cpuRunEn(cpuRunEn), .enterHandler(enterHandler)
  );

  // [13] mode 0=halt 1=sleep, [12:2] stimulus, [1] expected run, [0] expected handler
  // stimulus order: itc acc wdtNmi nmiLow dbg wdtRst extRst port portEn rtc rtcEn
  localparam int NV = 23;
  localparam logic [13:0] VECS [NV] = '{
    14'b0_10000000000_1_0,  // R1 itc, not accepted
    14'b0_11000000000_1_1,  // R1 R4 itc accepted
    14'b0_00100000000_1_0,  // R1 watchdog nmi
    14'b0_00010000000_1_0,  // R1 R6 nmi pin low
    14'b0_00001000000_1_0,  // R1 debug
    14'b0_00000100000_1_0,  // R1 R5 watchdog reset
    14'b0_00000010000_1_0,  // R1 R5 pin reset
    14'b0_11000010000_1_0,  // R5 reset overrides handler
    14'b0_00000001100_0_0,  // R3 port does not wake halt
    14'b0_00000000011_0_0,  // R3 rtc does not wake halt
    14'b0_01000000000_0_0,  // R4 accept alone
    14'b1_00000001100_1_0,  // R2 enabled port
    14'b1_00000001000_0_0,  // R3 masked port
    14'b1_00000000011_1_0,  // R2 enabled rtc
    14'b1_00000000010_0_0,  // R3 masked rtc
    14'b1_00010000000_1_0,  // R2 R6 nmi pin
    14'b1_00000010000_1_0,  // R2 R5 pin reset
    14'b1_00100000000_0_0,  // R2 watchdog nmi ignored
    14'b1_00000100000_0_0,  // R2 watchdog reset ignored
    14'b1_00001000000_0_0,  // R2 debug ignored
    14'b1_11000000000_0_0,  // R2 itc ignored
    14'b1_11000001100_1_1,  // R4 port wake with accepted itc
    14'b1_01000000000_0_0   // R2 accept alone
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input logic er, input logic eh);
    check(cpuRunEn === er, req, int'(cpuRunEn), int'(er));
    check(enterHandler === eh, req, int'(enterHandler), int'(eh));
  endtask

  task automatic clearIn();
    haltCmd = 0; sleepCmd = 0; itcReq = 0; cpuIntAccept = 0; wdtNmi = 0;
    nmiPinN = 1; dbgInt = 0; wdtRst = 0; extRst = 0;
    portIrq = '0; portIrqEn = '0; rtcIrq = '0; rtcIrqEn = '0;
  endtask

  task automatic applyStim(input logic [10:0] s);
    itcReq = s[10]; cpuIntAccept = s[9]; wdtNmi = s[8]; nmiPinN = ~s[7];
    dbgInt = s[6]; wdtRst = s[5]; extRst = s[4];
    portIrq[0] = s[3]; portIrqEn[0] = s[2]; rtcIrq[0] = s[1]; rtcIrqEn[0] = s[0];
  endtask

  task automatic recover();
    @(negedge clk); clearIn(); extRst = 1;
    @(negedge clk); clearIn();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    clearIn();
    repeat (3) @(negedge clk);
    checkOut("R10 in reset", 1'b1, 1'b0);
    rstN = 1;
    @(negedge clk);
    checkOut("R10 after reset", 1'b1, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [13:0] vec;
      string tag;
      vec = VECS[v];
      tag = vec[13] ? "R2 sleep vector" : "R1 halt vector";
      recover();
      if (vec[13]) sleepCmd = 1; else haltCmd = 1;
      @(negedge clk); clearIn();
      checkOut("R9 entered low power", 1'b0, 1'b0);
      applyStim(vec[12:2]);
      @(negedge clk);
      checkOut(tag, vec[1], vec[0]);
      clearIn();
      @(negedge clk);
      checkOut("R9 held after stimulus", vec[1], vec[0]);
    end

    // R7: halt command blocked by a pending debug interrupt
    recover();
    haltCmd = 1; dbgInt = 1;
    @(negedge clk); clearIn();
    checkOut("R7 halt blocked", 1'b1, 1'b0);
    // R7: sleep command blocked by an enabled rtc line
    sleepCmd = 1; rtcIrq[0] = 1; rtcIrqEn[0] = 1;
    @(negedge clk); clearIn();
    checkOut("R7 sleep blocked", 1'b1, 1'b0);
    // R7: a halt-only source does not block sleep
    sleepCmd = 1; wdtNmi = 1;
    @(negedge clk); clearIn();
    checkOut("R7 sleep not blocked by wdt nmi", 1'b0, 1'b0);
    dbgInt = 1;
    @(negedge clk); clearIn();
    checkOut("R2 still asleep", 1'b0, 1'b0);

    // R8: both commands -> HALT, proven by a watchdog NMI wake
    recover();
    haltCmd = 1; sleepCmd = 1;
    @(negedge clk); clearIn();
    checkOut("R8 low power", 1'b0, 1'b0);
    wdtNmi = 1;
    @(negedge clk); clearIn();
    checkOut("R8 was halt", 1'b1, 1'b0);

    // R9: sleep command while halted is ignored
    recover();
    haltCmd = 1;
    @(negedge clk); clearIn();
    sleepCmd = 1;
    @(negedge clk); clearIn();
    checkOut("R9 cmd in halt", 1'b0, 1'b0);
    dbgInt = 1; itcReq = 1; cpuIntAccept = 1;
    @(negedge clk); clearIn();
    checkOut("R9 still halt-woken R4", 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    checkOut("R9 handler flag held", 1'b1, 1'b1);
    // R5: watchdog reset in RUN clears the flag
    wdtRst = 1;
    @(negedge clk); clearIn();
    checkOut("R5 wdt reset clears flag", 1'b1, 1'b0);
    // R9: entering sleep clears the flag
    haltCmd = 1;
    @(negedge clk); clearIn();
    itcReq = 1; cpuIntAccept = 1;
    @(negedge clk); clearIn();
    checkOut("R4 handler set", 1'b1, 1'b1);
    sleepCmd = 1;
    @(negedge clk); clearIn();
    checkOut("R9 sleep clears flag", 1'b0, 1'b0);
    // R3: higher port line with enable wakes, a different enable does not
    portIrq = 4'b0100; portIrqEn = 4'b1011;
    @(negedge clk); clearIn();
    checkOut("R3 mismatched enable", 1'b0, 1'b0);
    portIrq = 4'b1000; portIrqEn = 4'b1000;
    @(negedge clk); clearIn();
    checkOut("R3 line 3 wakes", 1'b1, 1'b0);

    // R10: block reset during sleep
    sleepCmd = 1;
    @(negedge clk); clearIn();
    rstN = 0;
    @(negedge clk);
    checkOut("R10 reset from sleep", 1'b1, 1'b0);
    rstN = 1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule